// File: doc/BRIEF.md
# Round-Robin Switch Allocator for a Five-Port Router

This block decides, once per clock, which buffered flits may cross the router's crossbar. Each input port holds several virtual channels (VCs). A VC whose head flit has been routed and has been given an output VC raises a request. The request names the output port it wants and the VC it holds on that port. The block grants at most one VC per input port and at most one input port per output port. The grants go back to the input side, and the crossbar select lines go to each output.

Allocation happens in two stages. In the first stage, a round-robin arbiter at each input picks one eligible VC. A VC is eligible when it is requesting, names a valid port, and its downstream VC has at least one free slot. In the second stage, a round-robin arbiter at each output picks one of the inputs whose first-stage choice targets that output. The five output arbiters work side by side in the same cycle. A first-stage pointer moves on only when its choice also wins in the second stage. A loser keeps its priority and asks again.

The block keeps one credit counter for each output VC. A counter drops on the same edge that registers a grant for that output VC, and it rises when the downstream router returns a slot. Grants and crossbar selects are registered and appear one cycle after the request. The block has no state machine. All of its state is in the round-robin pointers, the credit counters and the registered grant outputs.

Top module: `sw_alloc_rr`

## Requirements
- R1: While reset is held and on the first cycle after it, every grant, VC index, crossbar valid and crossbar select output reads zero. All credit counters start at CRED_DEPTH, and all round-robin pointers start at index 0.
- R2: The grants for the requests presented before a clock edge appear on the outputs just after that edge, one cycle later.
- R3: Output ports are encoded 0 to 4. A request to a port code of 5 or more is never granted. A request whose target output VC has a credit count of zero is never granted.
- R4: No input is selected by two outputs in the same cycle, and each input is granted at most one VC. The number of valid input grants equals the number of valid crossbar selects. The VC-index and select fields of ports without a grant read zero.
- R5: At each input, the first stage chooses the first eligible VC, searching upward and wrapping from the VC just after the last VC of that input that won a grant.
- R6: At each output, the second stage chooses the first competing input, searching upward and wrapping from the input just after the last input granted on that output.
- R7: When an input's first-stage choice loses the second stage, that input's VC pointer does not move.
- R8: Each grant removes one credit from its output VC on the grant edge. With no credits returned, one output VC receives at most CRED_DEPTH grants.
- R9: A credit returned in the same cycle as a grant on that output VC leaves the count unchanged. A credit returned while the count is zero does not make a same-cycle request eligible.
- R10: All outputs are allocated in the same cycle. Inputs whose choices target distinct outputs are all granted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS*NUM_VC | Request per input VC, index port*NUM_VC+vc |
| req_oport | input | NUM_PORTS*NUM_VC*PORT_W | Requested output port per input VC |
| req_ovc | input | NUM_PORTS*NUM_VC*VC_W | Output VC held by each input VC |
| cred_ret | input | NUM_PORTS*NUM_VC | Credit returned per output VC, index out*NUM_VC+vc |
| in_gnt_valid | output | NUM_PORTS | Registered grant per input port |
| in_gnt_vc | output | NUM_PORTS*VC_W | Granted VC per input port |
| xbar_valid | output | NUM_PORTS | Registered crossbar enable per output port |
| xbar_sel | output | NUM_PORTS*PORT_W | Input port routed to each output |

## Verification
The bench targets these corner cases:
- **Several inputs on one output over consecutive cycles.** A design that resets or freezes its output pointer would keep serving the same input.
- **An input whose VC loses the second stage.** A pointer that moves on a lost grant would skip that VC on the next cycle, and the exact grant comparison reports it.
- **Draining one output VC to zero credits, then returning a credit in the same cycle as a request or a grant.** An off-by-one counter, or an eligibility test that sees the returned credit early, gives one grant too many or one too few.
- **Port codes 5 and 6, and all five inputs aimed at distinct outputs together.** These catch decoders that alias invalid ports and allocators that serialise the outputs.

// File: rtl/sa_pkg.sv
package sa_pkg;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_NORTH = 3'd1,
        PORT_EAST  = 3'd2,
        PORT_SOUTH = 3'd3,
        PORT_WEST  = 3'd4
    } port_e;

    // Wrap-around successor used by the round-robin pointers.
    function automatic int rr_next(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/sa_rr_arb.sv
module sa_rr_arb
    import sa_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_any
);

    logic [IW-1:0] ptr_q;
    logic [N-1:0]  gnt_oh;

    // Search upward from the pointer, wrapping, first requester wins.
    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int k = 0; k < N; k++) begin
            if (!gnt_any && req[(int'(ptr_q) + k) % N]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'((int'(ptr_q) + k) % N);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            gnt_oh[i] = gnt_any && (gnt_idx == IW'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance && gnt_any) begin
            ptr_q <= IW'(rr_next(int'(gnt_idx), N));
        end
    end

    assert_grant_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_oh & ~req) == '0) && $onehot0(gnt_oh));

    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(advance && gnt_any) |=> $stable(ptr_q));

endmodule

// File: rtl/sa_credit_bank.sv
module sa_credit_bank #(
    parameter int NUM_OUT = 5,
    parameter int NUM_VC  = 2,
    parameter int DEPTH   = 4,
    parameter int CW      = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_OUT*NUM_VC-1:0]   take,
    input  logic [NUM_OUT*NUM_VC-1:0]   give,
    output logic [NUM_OUT*NUM_VC-1:0]   avail
);

    localparam int NCNT = NUM_OUT * NUM_VC;

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= CW'(DEPTH);
            end else begin
                cnt_q <= cnt_q + CW'(give[i]) - CW'(take[i]);
            end
        end

        assign avail[i] = (cnt_q != '0);

        assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            take[i] |-> (cnt_q != '0));

        assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CW'(DEPTH));
    end

endmodule

// File: rtl/sa_vc_select.sv
module sa_vc_select #(
    parameter int NUM_PORTS = 5,
    parameter int NUM_VC    = 2,
    parameter int PW        = 3,
    parameter int VW        = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_VC-1:0]              vc_req,
    input  logic [NUM_VC*PW-1:0]           vc_port,
    input  logic [NUM_VC*VW-1:0]           vc_ovc,
    input  logic [NUM_PORTS*NUM_VC-1:0]    avail,
    input  logic                           won,
    output logic                           pick_any,
    output logic [VW-1:0]                  pick_vc,
    output logic [PW-1:0]                  pick_port,
    output logic [VW-1:0]                  pick_ovc
);

    logic [NUM_VC-1:0] elig;

    // A VC competes only with a valid port and a free downstream slot.
    always_comb begin
        for (int v = 0; v < NUM_VC; v++) begin
            elig[v] = 1'b0;
            if (vc_req[v]
                && (int'(vc_port[v*PW +: PW]) < NUM_PORTS)
                && (int'(vc_ovc[v*VW +: VW]) < NUM_VC)) begin
                elig[v] = avail[int'(vc_port[v*PW +: PW]) * NUM_VC
                                + int'(vc_ovc[v*VW +: VW])];
            end
        end
    end

    sa_rr_arb #(
        .N  (NUM_VC),
        .IW (VW)
    ) u_vc_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (elig),
        .advance (won),
        .gnt_idx (pick_vc),
        .gnt_any (pick_any)
    );

    assign pick_port = vc_port[int'(pick_vc)*PW +: PW];
    assign pick_ovc  = vc_ovc[int'(pick_vc)*VW +: VW];

    assert_pick_has_credit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> ((int'(pick_port) < NUM_PORTS) && vc_req[pick_vc]
                      && avail[int'(pick_port)*NUM_VC + int'(pick_ovc)]));

    assert_loser_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        won |-> pick_any);

endmodule

// File: rtl/sw_alloc_rr.sv
module sw_alloc_rr
    import sa_pkg::*;
#(
    parameter int NUM_PORTS  = 5,
    parameter int NUM_VC     = 2,
    parameter int CRED_DEPTH = 4,
    parameter int PORT_W     = $clog2(NUM_PORTS),
    parameter int VC_W       = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_PORTS*NUM_VC-1:0]        req_valid,
    input  logic [NUM_PORTS*NUM_VC*PORT_W-1:0] req_oport,
    input  logic [NUM_PORTS*NUM_VC*VC_W-1:0]   req_ovc,
    input  logic [NUM_PORTS*NUM_VC-1:0]        cred_ret,
    output logic [NUM_PORTS-1:0]               in_gnt_valid,
    output logic [NUM_PORTS*VC_W-1:0]          in_gnt_vc,
    output logic [NUM_PORTS-1:0]               xbar_valid,
    output logic [NUM_PORTS*PORT_W-1:0]        xbar_sel
);

    localparam int NREQ = NUM_PORTS * NUM_VC;

    logic [NUM_PORTS-1:0] s1_any;
    logic [VC_W-1:0]      s1_vc   [NUM_PORTS];
    logic [PORT_W-1:0]    s1_port [NUM_PORTS];
    logic [VC_W-1:0]      s1_ovc  [NUM_PORTS];
    logic [NUM_PORTS-1:0] in_won;
    logic [NUM_PORTS-1:0] oreq    [NUM_PORTS];
    logic [NUM_PORTS-1:0] s2_any;
    logic [PORT_W-1:0]    s2_idx  [NUM_PORTS];
    logic [NREQ-1:0]      avail;
    logic [NREQ-1:0]      take;

    // Stage 1: one VC per input.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_in
        sa_vc_select #(
            .NUM_PORTS (NUM_PORTS),
            .NUM_VC    (NUM_VC),
            .PW        (PORT_W),
            .VW        (VC_W)
        ) u_sel (
            .clk       (clk),
            .rst_n     (rst_n),
            .vc_req    (req_valid[p*NUM_VC +: NUM_VC]),
            .vc_port   (req_oport[p*NUM_VC*PORT_W +: NUM_VC*PORT_W]),
            .vc_ovc    (req_ovc[p*NUM_VC*VC_W +: NUM_VC*VC_W]),
            .avail     (avail),
            .won       (in_won[p]),
            .pick_any  (s1_any[p]),
            .pick_vc   (s1_vc[p]),
            .pick_port (s1_port[p]),
            .pick_ovc  (s1_ovc[p])
        );
    end

    // Route stage-1 winners to the output they target.
    always_comb begin
        for (int o = 0; o < NUM_PORTS; o++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                oreq[o][p] = s1_any[p] && (s1_port[p] == PORT_W'(o));
            end
        end
    end

    // Stage 2: one input per output, all outputs in parallel.
    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
        sa_rr_arb #(
            .N  (NUM_PORTS),
            .IW (PORT_W)
        ) u_port_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (oreq[o]),
            .advance (1'b1),
            .gnt_idx (s2_idx[o]),
            .gnt_any (s2_any[o])
        );
    end

    // Feed the outcome back to stage 1 and to the credit counters.
    always_comb begin
        in_won = '0;
        take   = '0;
        for (int o = 0; o < NUM_PORTS; o++) begin
            if (s2_any[o]) begin
                in_won[s2_idx[o]] = 1'b1;
                take[o*NUM_VC + int'(s1_ovc[s2_idx[o]])] = 1'b1;
            end
        end
    end

    sa_credit_bank #(
        .NUM_OUT (NUM_PORTS),
        .NUM_VC  (NUM_VC),
        .DEPTH   (CRED_DEPTH)
    ) u_credits (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .give  (cred_ret),
        .avail (avail)
    );

    // Registered grant and crossbar select outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_gnt_valid <= '0;
            in_gnt_vc    <= '0;
            xbar_valid   <= '0;
            xbar_sel     <= '0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                in_gnt_valid[p]              <= in_won[p];
                in_gnt_vc[p*VC_W +: VC_W]    <= in_won[p] ? s1_vc[p] : '0;
                xbar_valid[p]                <= s2_any[p];
                xbar_sel[p*PORT_W +: PORT_W] <= s2_any[p] ? s2_idx[p] : '0;
            end
        end
    end

    for (genvar a = 0; a < NUM_PORTS; a++) begin : g_chk_a
        for (genvar b = a + 1; b < NUM_PORTS; b++) begin : g_chk_b
            assert_distinct_inputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (xbar_valid[a] && xbar_valid[b])
                |-> (xbar_sel[a*PORT_W +: PORT_W] != xbar_sel[b*PORT_W +: PORT_W]));
        end
    end

    assert_grant_balance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_gnt_valid) == $countones(xbar_valid));

    assert_grant_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) == 1'b0 |=> (in_gnt_valid == '0));

endmodule

// File: tb/sw_alloc_rr_tb.sv
module sw_alloc_rr_tb;
    import sa_pkg::*;

    localparam int NP = 5;
    localparam int NV = 2;
    localparam int DEPTH = 4;
    localparam int PW = 3;
    localparam int VW = 1;
    localparam int NR = NP * NV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0]    req_valid = '0;
    logic [NR*PW-1:0] req_oport = '0;
    logic [NR*VW-1:0] req_ovc = '0;
    logic [NR-1:0]    cred_ret = '0;
    logic [NP-1:0]    in_gnt_valid;
    logic [NP*VW-1:0] in_gnt_vc;
    logic [NP-1:0]    xbar_valid;
    logic [NP*PW-1:0] xbar_sel;

    always #2 clk = ~clk;

    sw_alloc_rr #(.NUM_PORTS(NP), .NUM_VC(NV), .CRED_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_oport(req_oport),
        .req_ovc(req_ovc), .cred_ret(cred_ret), .in_gnt_valid(in_gnt_valid),
        .in_gnt_vc(in_gnt_vc), .xbar_valid(xbar_valid), .xbar_sel(xbar_sel)
    );

    typedef struct {
        int               due;
        logic [NP-1:0]    iv;
        logic [NP*VW-1:0] ivc;
        logic [NP-1:0]    xv;
        logic [NP*PW-1:0] xs;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state derived from the requirements.
    int m_ptr1 [NP];
    int m_ptr2 [NP];
    int m_cred [NP][NV];

    // Staged stimulus for the next cycle.
    logic [NR-1:0]    s_valid;
    logic [NR*PW-1:0] s_oport;
    logic [NR*VW-1:0] s_ovc;
    logic [NR-1:0]    s_ret;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual cyc=%0d expected below 20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Monitor: compare outputs against queued expectations.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (in_gnt_valid !== e.iv || in_gnt_vc !== e.ivc ||
                xbar_valid !== e.xv || xbar_sel !== e.xs) begin
                errors++;
                $display("FAIL %s cyc=%0d actual iv=%b ivc=%b xv=%b xs=%h expected iv=%b ivc=%b xv=%b xs=%h",
                         e.tag, cyc, in_gnt_valid, in_gnt_vc, xbar_valid, xbar_sel,
                         e.iv, e.ivc, e.xv, e.xs);
            end
        end
    end

    task automatic clear_stage();
        s_valid = '0; s_oport = '0; s_ovc = '0; s_ret = '0;
    endtask

    task automatic set_req(input int p, input int v, input int port, input int ovc);
        s_valid[p*NV+v] = 1'b1;
        s_oport[(p*NV+v)*PW +: PW] = PW'(port);
        s_ovc[(p*NV+v)*VW +: VW] = VW'(ovc);
    endtask

    task automatic set_ret(input int o, input int v);
        if (m_cred[o][v] < DEPTH) s_ret[o*NV+v] = 1'b1;
    endtask

    // Driver: apply stimulus, predict grants, push expectation.
    task automatic step(input string tag);
        exp_t e;
        bit   has1 [NP];
        int   ch_v [NP];
        int   ch_port [NP];
        int   ch_ovc [NP];
        @(negedge clk);
        req_valid = s_valid; req_oport = s_oport; req_ovc = s_ovc; cred_ret = s_ret;
        e.due = cyc + 1; e.tag = tag;
        e.iv = '0; e.ivc = '0; e.xv = '0; e.xs = '0;
        for (int p = 0; p < NP; p++) begin
            has1[p] = 1'b0; ch_v[p] = 0; ch_port[p] = 0; ch_ovc[p] = 0;
            for (int k = 0; k < NV; k++) begin
                int v, idx, prt, ov;
                v = (m_ptr1[p] + k) % NV;
                idx = p*NV + v;
                prt = int'(s_oport[idx*PW +: PW]);
                ov = int'(s_ovc[idx*VW +: VW]);
                if (!has1[p] && s_valid[idx] && prt < NP && ov < NV) begin
                    if (m_cred[prt][ov] > 0) begin
                        has1[p] = 1'b1; ch_v[p] = v; ch_port[p] = prt; ch_ovc[p] = ov;
                    end
                end
            end
        end
        for (int o = 0; o < NP; o++) begin
            bit found;
            found = 1'b0;
            for (int k = 0; k < NP; k++) begin
                int p;
                p = (m_ptr2[o] + k) % NP;
                if (!found && has1[p] && ch_port[p] == o) begin
                    found = 1'b1;
                    e.xv[o] = 1'b1;
                    e.xs[o*PW +: PW] = PW'(p);
                    e.iv[p] = 1'b1;
                    e.ivc[p*VW +: VW] = VW'(ch_v[p]);
                    m_ptr2[o] = (p + 1) % NP;
                    m_ptr1[p] = (ch_v[p] + 1) % NV;
                    m_cred[o][ch_ovc[p]]--;
                end
            end
        end
        for (int i = 0; i < NR; i++) begin
            if (s_ret[i]) m_cred[i/NV][i%NV]++;
        end
        exp_q.push_back(e);
    endtask

    initial begin
        for (int i = 0; i < NP; i++) begin
            m_ptr1[i] = 0; m_ptr2[i] = 0;
            for (int v = 0; v < NV; v++) m_cred[i][v] = DEPTH;
        end
        clear_stage();
        repeat (3) @(negedge clk);
        // R1: outputs idle under reset
        checks++;
        if (in_gnt_valid !== '0 || in_gnt_vc !== '0 || xbar_valid !== '0 || xbar_sel !== '0) begin
            errors++;
            $display("FAIL R1 actual iv=%b xv=%b xs=%h expected all zero",
                     in_gnt_valid, xbar_valid, xbar_sel);
        end
        rst_n = 1'b1;
        clear_stage(); step("R1");

        // R2: single request granted one cycle later
        clear_stage(); set_req(0, 0, PORT_EAST, 0); step("R2");
        clear_stage(); step("R2");

        // R3: invalid port codes are never granted
        clear_stage(); set_req(4, 0, 5, 0); set_req(4, 1, 6, 1); step("R3");
        clear_stage(); step("R3");

        // R10: five inputs to five distinct outputs in one cycle
        clear_stage();
        set_req(0, 0, PORT_WEST, 1); set_req(1, 1, PORT_LOCAL, 0);
        set_req(2, 0, PORT_NORTH, 1); set_req(3, 1, PORT_EAST, 1);
        set_req(4, 0, PORT_SOUTH, 0);
        step("R10");

        // R5: two eligible VCs at one input alternate
        for (int i = 0; i < 4; i++) begin
            clear_stage();
            set_req(1, 0, PORT_NORTH, 0); set_req(1, 1, PORT_EAST, 0);
            set_ret(1, 0); set_ret(2, 0);
            step("R5");
        end

        // R6: three inputs on one output rotate
        for (int i = 0; i < 6; i++) begin
            clear_stage();
            set_req(0, 1, PORT_WEST, 0); set_req(2, 0, PORT_WEST, 1);
            set_req(4, 1, PORT_WEST, 0);
            set_ret(4, 0); set_ret(4, 1);
            step("R6");
        end

        // R7: losing input keeps its VC pointer
        for (int i = 0; i < 5; i++) begin
            clear_stage();
            set_req(0, 0, PORT_EAST, 1); set_req(0, 1, PORT_SOUTH, 0);
            set_req(3, 0, PORT_EAST, 0); set_req(3, 1, PORT_EAST, 0);
            set_ret(2, 0); set_ret(2, 1); set_ret(3, 0);
            step("R7");
        end

        // R8: credits of one output VC run out after DEPTH grants
        for (int i = 0; i < DEPTH + 2; i++) begin
            clear_stage(); set_req(2, 1, PORT_LOCAL, 1); step("R8");
        end

        // R9: return with empty counter, then return alongside grant
        clear_stage(); set_req(2, 1, PORT_LOCAL, 1); set_ret(0, 1); step("R9");
        clear_stage(); set_req(2, 1, PORT_LOCAL, 1); set_ret(0, 1); step("R9");
        clear_stage(); set_req(2, 1, PORT_LOCAL, 1); step("R9");
        clear_stage(); set_req(2, 1, PORT_LOCAL, 1); step("R9");
        clear_stage(); step("R9");

        // R4: mixed random traffic, exact grant matching
        for (int n = 0; n < 600; n++) begin
            clear_stage();
            for (int i = 0; i < NR; i++) begin
                if ($urandom % 3 != 0) begin
                    set_req(i / NV, i % NV, int'($urandom % 6), int'($urandom % NV));
                end
                if ($urandom % 3 == 0) set_ret(i / NV, i % NV);
            end
            step("R4");
        end

        clear_stage(); step("R4");
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 actual pending=%0d expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule